// File: doc/BRIEF.md
# I2C Master Bus Timeout Timer

This block guards an I2C master against a stalled bus. It counts I2C bit periods, each marked by a one-cycle tick from the clock generator. If the count reaches the programmed limit before any qualifying bus activity, it raises a sticky timeout flag. Three kinds of activity clear the count and start it again from zero: a START request, a STOP request, and each falling edge of SCL.

The limit is an 8-bit setting. A value of zero turns the timer off. Any other value N gives a window of N + 1 bit periods. SCL arrives asynchronously, so it passes through a two-flop synchronizer before the edge detector. Once the limit is reached, the count stays at its end value. The flag can therefore fire only once per quiet stretch, even if software clears it early.

Top module: `i2c_bus_timeout`

## Requirements
- R1: During reset and at the first clock edge after reset, `to_flag` is 0. The synchronized SCL state resets to the idle-high level.
- R2: While `to_limit` is 0x00, the counter stays at zero and `to_flag` never goes from 0 to 1, whatever the ticks and bus events.
- R3: For a nonzero `to_limit` N, and with no restart event, `to_flag` becomes 1 at the clock edge that samples the (N+1)-th `bit_tick` since the last restart. It does not become 1 at any earlier edge.
- R4: A cycle with `start_req` high clears the count to zero. The next tick after that is counted as tick 1.
- R5: A cycle with `stop_req` high clears the count to zero. The next tick after that is counted as tick 1.
- R6: A falling edge of `scl_in` clears the count. If `scl_in` is sampled 1 at edge k-3 and 0 at edge k-2, the clear takes effect at edge k. A rising edge of SCL does not clear the count.
- R7: When a restart event and `bit_tick` fall in the same cycle, the restart wins. That tick is not counted and cannot cause an expiry.
- R8: `to_flag` stays at 1 until a cycle with `flag_clr` high clears it. If `flag_clr` is high in the same cycle as a new expiry, the flag stays at 1.
- R9: After an expiry, the count holds at its end value. Further ticks cause no second expiry until a restart event occurs, so a cleared flag stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| to_limit | input | TW | Timeout setting; zero disables the timer |
| start_req | input | 1 | One-cycle START request pulse |
| stop_req | input | 1 | One-cycle STOP request pulse |
| scl_in | input | 1 | SCL line level, asynchronous |
| bit_tick | input | 1 | One-cycle pulse per I2C bit period |
| flag_clr | input | 1 | Clears the timeout flag |
| to_flag | output | 1 | Sticky timeout interrupt flag |

## Verification
The bench runs directed sequences, each aimed at one rule:
- A zero setting with a long run of ticks, which must never set the flag.
- Exact tick counts one short of the limit and exactly at it, which separates an off-by-one window from a correct one.
- A START, a STOP or an SCL fall placed partway through a window, which shows whether the count really restarted. Restarts that coincide with a tick, and clears that coincide with an expiry, check the priority rules.

A long random phase then mixes settings, pulses, slow SCL toggling and clears, against a bench model of the count. This exposes any mistake in event latency or in holding the count after expiry.

// File: rtl/i2c_bus_timeout.sv
module i2c_bus_timeout #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] to_limit,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic          scl_in,
  input  logic          bit_tick,
  input  logic          flag_clr,
  output logic          to_flag
);
  localparam int CW = TW + 1;

  logic          scl_m, scl_s, scl_d;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          scl_fall, restart, enabled, expire;

  assign lim      = {1'b0, to_limit};
  assign scl_fall = scl_d & ~scl_s;
  assign restart  = start_req | stop_req | scl_fall;
  assign enabled  = |to_limit;
  assign expire   = enabled & ~restart & bit_tick & (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1;
      scl_s <= 1'b1;
      scl_d <= 1'b1;
    end else begin
      scl_m <= scl_in;
      scl_s <= scl_m;
      scl_d <= scl_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart || !enabled)
      cnt <= '0;
    else if (bit_tick && cnt <= lim)
      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      to_flag <= 1'b0;
    else if (expire)
      to_flag <= 1'b1;
    else if (flag_clr)
      to_flag <= 1'b0;
  end
endmodule

module i2c_bus_timeout_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] to_limit,
  input logic          start_req,
  input logic          stop_req,
  input logic          bit_tick,
  input logic          flag_clr,
  input logic          to_flag
);
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> !to_flag);

  a_r2_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (to_limit == '0 && !to_flag) |=> !to_flag);

  a_r3_set_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_flag) |-> $past(bit_tick));

  a_r4_start_blocks_set: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !to_flag) |=> !to_flag);

  a_r5_stop_blocks_set: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !to_flag) |=> !to_flag);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (to_flag && !flag_clr) |=> to_flag);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (to_flag && flag_clr && !bit_tick) |=> !to_flag);
endmodule

bind i2c_bus_timeout i2c_bus_timeout_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .to_limit(to_limit), .start_req(start_req),
  .stop_req(stop_req), .bit_tick(bit_tick), .flag_clr(flag_clr),
  .to_flag(to_flag)
);

// File: tb/test_i2c_bus_timeout.sv
module test_i2c_bus_timeout;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] to_limit = '0;
  logic          start_req = 1'b0, stop_req = 1'b0, scl_in = 1'b1;
  logic          bit_tick = 1'b0, flag_clr = 1'b0;
  logic          to_flag;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // bench reference state
  int m_cnt   = 0;
  bit m_flag  = 1'b0;
  bit h1 = 1'b1, h2 = 1'b1, h3 = 1'b1;

  i2c_bus_timeout #(.TW(TW)) i_i2c_bus_timeout (
    .clk(clk), .rst_n(rst_n), .to_limit(to_limit), .start_req(start_req),
    .stop_req(stop_req), .scl_in(scl_in), .bit_tick(bit_tick),
    .flag_clr(flag_clr), .to_flag(to_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit next_flag(bit f, bit exp_now, bit clr);
    if (exp_now) return 1'b1;
    if (clr) return 1'b0;
    return f;
  endfunction

  task automatic model_edge();
    bit fall, rs, en, ex;
    fall = h3 & ~h2;                        // R6 latency
    rs   = start_req | stop_req | fall;     // R4 R5 R6 R7
    en   = (to_limit != 0);                 // R2
    ex   = en && !rs && bit_tick && (m_cnt == int'(to_limit));
    if (rs || !en) m_cnt = 0;
    else if (bit_tick && m_cnt <= int'(to_limit)) m_cnt++;  // R9 hold
    m_flag = next_flag(m_flag, ex, flag_clr);
    h3 = h2; h2 = h1; h1 = scl_in;
  endtask

  task automatic check(bit exp, string tag);
    vectors++;
    if (to_flag !== exp) begin
      errors++;
      $display("FAIL %s: to_flag=%b expected=%b at %0t", tag, to_flag, exp, $time);
    end
  endtask

  task automatic step(bit st, bit sp, bit tk, bit cl, string tag);
    start_req = st; stop_req = sp; bit_tick = tk; flag_clr = cl;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    start_req = 0; stop_req = 0; bit_tick = 0; flag_clr = 0;
    check(m_flag, tag);
  endtask

  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 1, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2 + 1);
    check(1'b0, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0, "R1");
    check(1'b0, "R1 after reset");

    // R2: disabled
    to_limit = 0;
    ticks(300, "R2");
    check(1'b0, "R2 zero setting");

    // R3: exact window N+1
    to_limit = 3;
    step(1, 0, 0, 0, "R4");
    ticks(3, "R3");
    check(1'b0, "R3 one short");
    ticks(1, "R3");
    check(1'b1, "R3 at limit");

    // R8 sticky, clear; R9 hold
    step(0, 0, 0, 0, "R8");
    check(1'b1, "R8 sticky");
    step(0, 0, 0, 1, "R8");
    check(1'b0, "R8 cleared");
    ticks(10, "R9");
    check(1'b0, "R9 no second expiry");

    // R4: start mid-window
    step(1, 0, 0, 0, "R4");
    ticks(2, "R4");
    step(1, 0, 0, 0, "R4");
    ticks(3, "R4");
    check(1'b0, "R4 restarted");
    ticks(1, "R4");
    check(1'b1, "R4 expiry after restart");
    step(0, 0, 0, 1, "R8");

    // R5: stop mid-window
    step(0, 1, 0, 0, "R5");
    ticks(3, "R5");
    step(0, 1, 0, 0, "R5");
    ticks(3, "R5");
    check(1'b0, "R5 restarted");
    ticks(1, "R5");
    check(1'b1, "R5 expiry after restart");
    step(0, 0, 0, 1, "R8");

    // R6: SCL fall restarts, rise does not
    step(1, 0, 0, 0, "R6");
    ticks(3, "R6");
    scl_in = 0;
    step(0, 0, 0, 0, "R6"); step(0, 0, 0, 0, "R6"); step(0, 0, 0, 0, "R6");
    ticks(3, "R6");
    check(1'b0, "R6 fall restarted");
    scl_in = 1;
    step(0, 0, 0, 0, "R6"); step(0, 0, 0, 0, "R6"); step(0, 0, 0, 0, "R6");
    ticks(1, "R6");
    check(1'b1, "R6 rise not a restart");
    step(0, 0, 0, 1, "R8");

    // R7: restart with tick in same cycle
    step(1, 0, 0, 0, "R7");
    ticks(3, "R7");
    step(1, 0, 1, 0, "R7");
    check(1'b0, "R7 restart wins");
    ticks(3, "R7");
    check(1'b0, "R7 tick not counted");
    ticks(1, "R7");
    check(1'b1, "R7 expiry");

    // R8: clear coincides with expiry
    step(0, 0, 0, 1, "R8");
    step(1, 0, 0, 0, "R8");
    ticks(3, "R8");
    step(0, 0, 1, 1, "R8");
    check(1'b1, "R8 clear loses to expiry");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 199) == 0) to_limit = TW'($urandom_range(0, 6));
      if ($urandom_range(0, 29) == 0) scl_in = ~scl_in;
      step($urandom_range(0, 39) == 0, $urandom_range(0, 49) == 0,
           $urandom_range(0, 2) == 0, $urandom_range(0, 19) == 0, "R3 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule